// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This controller picks the operating mode of a three-rail memory power supply: a main switching rail, a termination rail that tracks half the main rail, and a secondary core switching rail. It reads two active-low sleep requests and a set of status flags from the analog side: reference good, main supply good, boot supply good, main rail in regulation, soft-start done, overcurrent, and two temperature comparator outputs. From these it drives the mode code, the per-rail enables, the standby and high-impedance controls, and the soft-start select. The analog loops, the comparators and the soft-start ramp are outside the block and appear only as flags.

The block has three modes. Full-on has all rails running. Sleep keeps the main rail in standby and turns the other two rails off. Shutdown turns everything off. On entry from shutdown the rails start in order: the main rail soft-starts first, and the termination and core rails follow once the main rail is regulating. An overcurrent seen in full-on latches every rail off until a supply or the shutdown request is cycled. A hot/cool flag pair gives the thermal shutdown its hysteresis.

Top module: `sleep_seq`

## Requirements
- R1: After reset the mode code is shutdown (2'd0). mainEn, mainStandby, termEn and coreEn are 0, termHiZ is 1 and ssSel is 2'b00. The mode codes are shutdown=0, sleep=1, full-on=2.
- R2: Every flag input passes through a two-flop synchronizer. A flag change that the bench applies before rising edge k moves the mode code after edge k+2.
- R3: Shutdown goes to full-on only when refOk, mainSupplyOk, bootSupplyOk, s3ReqN and s5ReqN are all high. With any of them low the block stays in shutdown.
- R4: From full-on, s5ReqN low gives shutdown, and this wins over s3ReqN. s3ReqN low with s5ReqN high gives sleep. Any other combination keeps full-on.
- R5: From sleep, s5ReqN low gives shutdown. s3ReqN high with bootSupplyOk high gives full-on. s3ReqN high with bootSupplyOk low gives shutdown. Any other combination keeps sleep.
- R6: On entry to full-on from shutdown only mainEn is set, with ssSel=2'b01 (main soft-start). termEn and coreEn go high, with termHiZ low, once mainInReg and softStartDone are both high.
- R7: In the core start phase ssSel=2'b10. After softStartDone has been seen low and then high again, ssSel returns to 2'b00 while all rails stay on.
- R8: In sleep, mainEn=1, mainStandby=1, termEn=0, termHiZ=1, coreEn=0 and ssSel=2'b00. A return from sleep to full-on skips the main phase and starts directly in the core start phase.
- R9: overCurrent in full-on drives all rail enables low in the cycle the synchronized flag appears, and the mode becomes shutdown. The latch holds the block in shutdown until mainSupplyOk, s5ReqN or bootSupplyOk is seen low.
- R10: overCurrent has no effect while in sleep.
- R11: tempHot turns every rail off and forces shutdown. The block stays off until tempCool is high while tempHot is low.
- R12: refOk or mainSupplyOk going low turns every rail off in the same cycle the synchronized flag appears, and the mode becomes shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| s3ReqN | input | 1 | Sleep request, active low |
| s5ReqN | input | 1 | Shutdown request, active low |
| refOk | input | 1 | Internal reference good |
| mainSupplyOk | input | 1 | Main supply above its undervoltage level |
| bootSupplyOk | input | 1 | Boot (gate-drive) supply good |
| mainInReg | input | 1 | Main rail in regulation |
| softStartDone | input | 1 | Shared soft-start ramp complete |
| overCurrent | input | 1 | Main rail high-side overcurrent |
| tempHot | input | 1 | Die above upper thermal threshold |
| tempCool | input | 1 | Die below lower thermal threshold |
| modeCode | output | 2 | 0 shutdown, 1 sleep, 2 full-on |
| mainEn | output | 1 | Main rail switching enable |
| mainStandby | output | 1 | Main rail standby (doubled frequency) |
| termEn | output | 1 | Termination rail enable |
| termHiZ | output | 1 | Termination output high impedance |
| coreEn | output | 1 | Core rail enable |
| ssSel | output | 2 | Soft-start owner: 00 none, 01 main, 10 core |

## Verification
The bench goes after four corner cases. First, the case where both sleep requests fall at once: a design that checks the sleep request first would park in sleep instead of shutting down. Second, a sleep exit with the boot supply still down: the block must fall to shutdown rather than start the rails without gate drive. Third, an overcurrent during sleep: a latch that is not qualified by mode would kill the standby rail. Fourth, overcurrent latch release, where the bench keeps all wake conditions true and checks that the block stays off until the shutdown request pulses. A design that merely waits for the flag to drop would restart into the short. The thermal pair is driven through a phase with both flags low, to show that a design without hysteresis resumes too early.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef struct packed {
    logic s3ReqN;
    logic s5ReqN;
    logic refOk;
    logic mainOk;
    logic bootOk;
    logic inReg;
    logic ssDone;
    logic overCurrent;
    logic tempHot;
    logic tempCool;
  } flagVec_t;

  localparam int FLAG_W = $bits(flagVec_t);

  typedef enum logic [2:0] {
    ST_S5 = 3'b001,
    ST_S3 = 3'b010,
    ST_S0 = 3'b100
  } pwrState_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAIN = 2'd1,
    PH_CORE = 2'd2,
    PH_RUN  = 2'd3
  } railPhase_t;

  typedef struct packed {
    logic inS0;
    logic mainOn;
    logic mainStby;
    logic termOn;
    logic coreOn;
    logic ssMain;
    logic ssCore;
  } seqStrobe_t;

  localparam logic [1:0] MODE_S5 = 2'd0;
  localparam logic [1:0] MODE_S3 = 2'd1;
  localparam logic [1:0] MODE_S0 = 2'd2;

  localparam logic [1:0] SS_NONE = 2'b00;
  localparam logic [1:0] SS_MAIN = 2'b01;
  localparam logic [1:0] SS_CORE = 2'b10;

endpackage

// File: rtl/sleep_seq_sync.sv
module sleep_seq_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[LAST];

endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  flagVec_t   rawFlags,
  input  seqStrobe_t strobe,
  output flagVec_t   syncFlags,
  output logic       holdOff,
  output logic       mainEn,
  output logic       mainStandby,
  output logic       termEn,
  output logic       termHiZ,
  output logic       coreEn,
  output logic [1:0] ssSel
);

  logic [FLAG_W-1:0] syncBits;
  logic ocNow, ocClear, ocLatched;
  logic thermShut, supplyLoss;
  logic unusedFlags;

  sleep_seq_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawFlags),
    .dout (syncBits)
  );
  assign syncFlags = flagVec_t'(syncBits);

  // overcurrent only counts while the rails are fully on
  assign ocNow      = syncFlags.overCurrent & strobe.inS0;
  assign ocClear    = ~syncFlags.mainOk | ~syncFlags.s5ReqN | ~syncFlags.bootOk;
  assign supplyLoss = ~syncFlags.refOk | ~syncFlags.mainOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ocLatched <= 1'b0;
    else if (ocClear) ocLatched <= 1'b0;
    else if (ocNow)   ocLatched <= 1'b1;
  end

  // hot sets, cool clears, hot wins when both are seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  thermShut <= 1'b0;
    else if (syncFlags.tempHot) thermShut <= 1'b1;
    else if (syncFlags.tempCool) thermShut <= 1'b0;
  end

  assign holdOff = ocNow | ocLatched | syncFlags.tempHot | thermShut | supplyLoss;

  always_comb begin
    mainEn      = strobe.mainOn   & ~holdOff;
    mainStandby = strobe.mainStby & ~holdOff;
    termEn      = strobe.termOn   & ~holdOff;
    coreEn      = strobe.coreOn   & ~holdOff;
    termHiZ     = ~termEn;
    if (holdOff)           ssSel = SS_NONE;
    else if (strobe.ssMain) ssSel = SS_MAIN;
    else if (strobe.ssCore) ssSel = SS_CORE;
    else                    ssSel = SS_NONE;
  end

  assign unusedFlags = ^{syncFlags.s3ReqN, syncFlags.inReg, syncFlags.ssDone};

  // R9
  oc_latch_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ocLatched |-> (!mainEn && !termEn && !coreEn));

  // R11
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    thermShut |-> (!mainEn && !mainStandby && !coreEn));

  // R6
  term_needs_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    termEn |-> (mainEn && !mainStandby && coreEn));

  // R7
  ss_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssSel != 2'b11);

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  flagVec_t   syncFlags,
  input  logic       holdOff,
  output seqStrobe_t strobe,
  output logic [1:0] modeCode
);

  pwrState_t  state, stateNxt;
  railPhase_t phase, phaseNxt;
  logic       lowSeen, lowSeenNxt;
  logic       wakeOk;
  logic       unusedFlags;

  assign wakeOk = syncFlags.s3ReqN & syncFlags.s5ReqN & syncFlags.bootOk;

  always_comb begin
    stateNxt   = state;
    phaseNxt   = phase;
    lowSeenNxt = lowSeen;
    if (holdOff) begin
      stateNxt   = ST_S5;
      phaseNxt   = PH_IDLE;
      lowSeenNxt = 1'b0;
    end else begin
      unique case (state)
        ST_S5: begin
          if (wakeOk) begin
            stateNxt   = ST_S0;
            phaseNxt   = PH_MAIN;
            lowSeenNxt = 1'b0;
          end
        end
        ST_S0: begin
          if (!syncFlags.s5ReqN) begin
            stateNxt = ST_S5;
            phaseNxt = PH_IDLE;
          end else if (!syncFlags.s3ReqN) begin
            stateNxt = ST_S3;
            phaseNxt = PH_IDLE;
          end else begin
            case (phase)
              PH_MAIN: if (syncFlags.inReg && syncFlags.ssDone) begin
                phaseNxt   = PH_CORE;
                lowSeenNxt = 1'b0;
              end
              PH_CORE: begin
                if (!syncFlags.ssDone) lowSeenNxt = 1'b1;
                if (syncFlags.ssDone && lowSeen) phaseNxt = PH_RUN;
              end
              PH_RUN:  phaseNxt = PH_RUN;
              default: phaseNxt = PH_MAIN;
            endcase
          end
        end
        ST_S3: begin
          if (!syncFlags.s5ReqN) begin
            stateNxt = ST_S5;
          end else if (syncFlags.s3ReqN && syncFlags.bootOk) begin
            stateNxt   = ST_S0;
            phaseNxt   = PH_CORE;
            lowSeenNxt = 1'b0;
          end else if (syncFlags.s3ReqN) begin
            stateNxt = ST_S5;
          end
        end
        default: begin
          stateNxt   = ST_S5;
          phaseNxt   = PH_IDLE;
          lowSeenNxt = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_S5;
      phase   <= PH_IDLE;
      lowSeen <= 1'b0;
    end else begin
      state   <= stateNxt;
      phase   <= phaseNxt;
      lowSeen <= lowSeenNxt;
    end
  end

  always_comb begin
    strobe.inS0     = (state == ST_S0);
    strobe.mainOn   = (state == ST_S0) || (state == ST_S3);
    strobe.mainStby = (state == ST_S3);
    strobe.termOn   = (state == ST_S0) && ((phase == PH_CORE) || (phase == PH_RUN));
    strobe.coreOn   = strobe.termOn;
    strobe.ssMain   = (state == ST_S0) && (phase == PH_MAIN);
    strobe.ssCore   = (state == ST_S0) && (phase == PH_CORE);
    case (state)
      ST_S0:   modeCode = MODE_S0;
      ST_S3:   modeCode = MODE_S3;
      default: modeCode = MODE_S5;
    endcase
  end

  assign unusedFlags = ^{syncFlags.refOk, syncFlags.mainOk, syncFlags.overCurrent,
                         syncFlags.tempHot, syncFlags.tempCool};

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(state));

  // R4
  s0_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S0 && !holdOff && !syncFlags.s5ReqN) |=> (state == ST_S5));

  // R5
  s3_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S3 && !holdOff && wakeOk) |=> (state == ST_S0 && phase == PH_CORE));

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       s3ReqN,
  input  logic       s5ReqN,
  input  logic       refOk,
  input  logic       mainSupplyOk,
  input  logic       bootSupplyOk,
  input  logic       mainInReg,
  input  logic       softStartDone,
  input  logic       overCurrent,
  input  logic       tempHot,
  input  logic       tempCool,
  output logic [1:0] modeCode,
  output logic       mainEn,
  output logic       mainStandby,
  output logic       termEn,
  output logic       termHiZ,
  output logic       coreEn,
  output logic [1:0] ssSel
);

  flagVec_t   rawFlags, syncFlags;
  seqStrobe_t strobe;
  logic       holdOff;

  assign rawFlags = {s3ReqN, s5ReqN, refOk, mainSupplyOk, bootSupplyOk,
                     mainInReg, softStartDone, overCurrent, tempHot, tempCool};

  sleep_seq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rawFlags    (rawFlags),
    .strobe      (strobe),
    .syncFlags   (syncFlags),
    .holdOff     (holdOff),
    .mainEn      (mainEn),
    .mainStandby (mainStandby),
    .termEn      (termEn),
    .termHiZ     (termHiZ),
    .coreEn      (coreEn),
    .ssSel       (ssSel)
  );

  sleep_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncFlags (syncFlags),
    .holdOff   (holdOff),
    .strobe    (strobe),
    .modeCode  (modeCode)
  );

endmodule

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic s3ReqN = 0, s5ReqN = 0, refOk = 0, mainSupplyOk = 0, bootSupplyOk = 0;
  logic mainInReg = 0, softStartDone = 0, overCurrent = 0, tempHot = 0, tempCool = 0;
  logic [1:0] modeCode, ssSel;
  logic mainEn, mainStandby, termEn, termHiZ, coreEn;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq u_sleep_seq (
    .clk(clk), .rstN(rstN), .s3ReqN(s3ReqN), .s5ReqN(s5ReqN), .refOk(refOk),
    .mainSupplyOk(mainSupplyOk), .bootSupplyOk(bootSupplyOk), .mainInReg(mainInReg),
    .softStartDone(softStartDone), .overCurrent(overCurrent), .tempHot(tempHot),
    .tempCool(tempCool), .modeCode(modeCode), .mainEn(mainEn), .mainStandby(mainStandby),
    .termEn(termEn), .termHiZ(termHiZ), .coreEn(coreEn), .ssSel(ssSel)
  );

  // reference model: mode 0 off, 1 sleep, 2 on; phase 0 idle, 1 main, 2 core, 3 run
  int mMode = 0, mPhase = 0;
  bit mLow = 0, mOc = 0, mTherm = 0;
  bit [9:0] flagQ[$] = '{10'd0, 10'd0};

  function automatic bit [9:0] packIn();
    return {s3ReqN, s5ReqN, refOk, mainSupplyOk, bootSupplyOk,
            mainInReg, softStartDone, overCurrent, tempHot, tempCool};
  endfunction

  function automatic bit faultOf(bit [9:0] f);
    // bits: 9 s3N 8 s5N 7 ref 6 mainOk 5 boot 4 inReg 3 ssDone 2 oc 1 hot 0 cool
    return (f[2] && mMode == 2) || mOc || f[1] || mTherm || !f[7] || !f[6];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPhase = 0; mLow = 0; mOc = 0; mTherm = 0;
      flagQ = '{10'd0, 10'd0};
    end else begin
      bit [9:0] f;
      bit flt, nOc, nTherm, nLow;
      int nMode, nPhase;
      f = flagQ[0];
      flt = faultOf(f);
      nOc = (!f[6] || !f[8] || !f[5]) ? 1'b0 : (mOc || (f[2] && mMode == 2));
      nTherm = f[1] ? 1'b1 : (f[0] ? 1'b0 : mTherm);
      nMode = mMode; nPhase = mPhase; nLow = mLow;
      if (flt) begin
        nMode = 0; nPhase = 0; nLow = 0;
      end else if (mMode == 0) begin
        if (f[9] && f[8] && f[5]) begin nMode = 2; nPhase = 1; nLow = 0; end
      end else if (mMode == 2) begin
        if (!f[8]) begin nMode = 0; nPhase = 0; end
        else if (!f[9]) begin nMode = 1; nPhase = 0; end
        else if (mPhase == 1 && f[4] && f[3]) begin nPhase = 2; nLow = 0; end
        else if (mPhase == 2) begin
          if (!f[3]) nLow = 1;
          if (f[3] && mLow) nPhase = 3;
        end
      end else begin
        if (!f[8]) nMode = 0;
        else if (f[9] && f[5]) begin nMode = 2; nPhase = 2; nLow = 0; end
        else if (f[9]) nMode = 0;
      end
      mMode = nMode; mPhase = nPhase; mLow = nLow; mOc = nOc; mTherm = nTherm;
      flagQ.push_back(packIn());
      void'(flagQ.pop_front());
    end
  end

  task automatic cmp(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit flt;
      int eMain, eStby, eTerm, eCore, eSs;
      flt = faultOf(flagQ[0]);
      eMain = 0; eStby = 0; eTerm = 0; eCore = 0; eSs = 0;
      if (!flt) begin
        if (mMode == 1) begin eMain = 1; eStby = 1; end
        if (mMode == 2) begin
          eMain = 1;
          if (mPhase >= 2) begin eTerm = 1; eCore = 1; end
          if (mPhase == 1) eSs = 1;
          if (mPhase == 2) eSs = 2;
        end
      end
      cmp("modeCode", modeCode, mMode);
      cmp("mainEn", mainEn, eMain);
      cmp("mainStandby", mainStandby, eStby);
      cmp("termEn", termEn, eTerm);
      cmp("termHiZ", termHiZ, !eTerm);
      cmp("coreEn", coreEn, eCore);
      cmp("ssSel", ssSel, eSs);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rampDone();
    softStartDone = 0; go(5);
    softStartDone = 1; go(6);
  endtask

  initial begin
    // R1 reset state
    curReq = "R1";
    go(4);
    rstN = 1; go(4);

    // R3 missing boot supply keeps shutdown
    curReq = "R3";
    refOk = 1; mainSupplyOk = 1; s3ReqN = 1; s5ReqN = 1; go(8);
    // R2 boot rise reaches mode after sync delay; R6 main rail alone
    curReq = "R2";
    bootSupplyOk = 1; go(3);
    curReq = "R6";
    go(5);
    mainInReg = 1; softStartDone = 1; go(6);
    // R7 core ramp then done
    curReq = "R7";
    rampDone();

    // R8 sleep outputs; R10 overcurrent ignored in sleep
    curReq = "R8";
    s3ReqN = 0; go(6);
    curReq = "R10";
    overCurrent = 1; go(6); overCurrent = 0; go(4);
    // R5 boot supply lost in sleep, then wake without it goes to shutdown
    curReq = "R5";
    bootSupplyOk = 0; go(5);
    s3ReqN = 1; go(6);
    bootSupplyOk = 1; go(6);
    rampDone();
    // R8 sleep and return into core phase
    curReq = "R8";
    s3ReqN = 0; go(6);
    s3ReqN = 1; go(6);
    rampDone();

    // R4 both requests fall together: shutdown wins
    curReq = "R4";
    s3ReqN = 0; s5ReqN = 0; go(6);
    s3ReqN = 1; s5ReqN = 1; go(6);
    rampDone();

    // R9 overcurrent latch, held until shutdown request pulses
    curReq = "R9";
    overCurrent = 1; go(4);
    overCurrent = 0; go(10);
    s5ReqN = 0; go(4);
    s5ReqN = 1; go(6);
    rampDone();

    // R11 thermal hysteresis
    curReq = "R11";
    tempHot = 1; go(5);
    tempHot = 0; go(8);
    tempCool = 1; go(8);
    tempCool = 0; go(4);
    rampDone();

    // R12 supply loss
    curReq = "R12";
    refOk = 0; go(5);
    refOk = 1; go(6);
    mainSupplyOk = 0; go(5);
    mainSupplyOk = 1; go(8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule